// File: doc/BRIEF.md
# Predicated Quadword Load-and-Broadcast Unit

This block carries out a single load-and-broadcast operation. A start pulse supplies a 64-bit base value, a 64-bit index, the identifier of the register that holds the index, a flag that marks the base as the stack pointer, and a 16-bit predicate slice. The unit forms an effective address, which is the base plus eight times the index with 64-bit wraparound. It then reads up to two 64-bit elements from consecutive doubleword addresses over a request/response memory port. Only one request is in flight at any time.

Each element fetch depends on its own predicate bit. An element that is not enabled causes no memory traffic, and its lane of the 128-bit quadword is zero. The finished quadword is copied across a destination vector whose width is a parameter. That width must be a multiple of 128 bits in the range 128 to 2048, and elaboration rejects any other value. The unit rejects two cases without touching memory: a reserved index register identifier, and a stack-pointer base that is not aligned. A memory error response also aborts the operation. Every operation ends with a one-cycle done pulse, and an error flag accompanies that pulse when the operation failed.

Top module: `qbcast_load`

## Requirements
- R1: The first element address is base_val + index_val*8, truncated to 64 bits (wraps around).
- R2: Element 0 is read from the effective address and element 1 from the effective address + 8, in that order. Element 0 fills vec_out bits [63:0] of each 128-bit tile and element 1 fills bits [127:64].
- R3: pred_slice bit 0 enables element 0 and bit 8 enables element 1. A disabled element issues no request, and its 64-bit lane is zero in the result.
- R4: pred_slice bits other than 0 and 8 have no effect on requests or on the result.
- R5: Every 128-bit tile k of vec_out, bits [128k+127:128k], holds the same quadword after a successful operation.
- R6: index_reg_id equal to 31 is rejected. done and error are high one cycle after start, no request is issued and vec_out is unchanged.
- R7: When base_is_sp is 1 and base_val[3:0] is nonzero, the operation is rejected in the same way as R6. An unaligned base with base_is_sp at 0, or an aligned stack-pointer base, proceeds normally.
- R8: mem_req_valid stays high with a stable mem_req_addr until mem_req_ready is high. No new request is issued before the response to the previous one arrives.
- R9: done is a one-cycle pulse. It is high in the cycle after the cycle in which the last active element's response is accepted, or in the cycle after start when no element is active. error is high only together with done.
- R10: A response with mem_rsp_err set ends the operation. No further request is issued, done and error rise one cycle later, and vec_out keeps its previous value.
- R11: A start pulse that arrives while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins an operation when the unit is idle |
| base_val | input | 64 | Base address value |
| base_is_sp | input | 1 | Base comes from the stack pointer (alignment checked) |
| index_val | input | 64 | Scalar index, scaled by 8 |
| index_reg_id | input | 5 | Identifier of the index register; 31 is reserved |
| pred_slice | input | 16 | Low predicate bits; bits 0 and 8 enable the elements |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Request byte address |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 64 | Read response data |
| mem_rsp_err | input | 1 | Read response carries an error |
| vec_out | output | VL_BITS | Replicated result vector |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Operation failed; valid with done |

## Verification
When the unit rejects an operation or finds no active element, done, error and vec_out become valid one cycle after the edge that samples start. Otherwise they become valid one cycle after the edge that accepts the final response. A memory stall delays that moment but does not change this relationship. The bench has a cycle counter that records the edge that sampled start, the edge of the last response and the edge on which done was seen. It samples the outputs on falling edges and compares those edge numbers against the expected offset of one. Request addresses and request counts are logged at the accepting edge, and the log is compared with the list the bench derives from the predicate bits.

// File: rtl/qbl_pkg.sv
package qbl_pkg;
   localparam int unsigned QBL_ADDR_W      = 64;
   localparam int unsigned QBL_ELEM_W      = 64;
   localparam int unsigned QBL_QUAD_W      = 128;
   localparam int unsigned QBL_PRED_W      = 16;
   localparam int unsigned QBL_ID_W        = 5;
   localparam int unsigned QBL_ALIGN_LOG2  = 4;
   localparam int unsigned QBL_VL_MIN      = 128;
   localparam int unsigned QBL_VL_MAX      = 2048;

   typedef enum logic [1:0] {
      QBL_IDLE = 2'd0,
      QBL_REQ  = 2'd1,
      QBL_WAIT = 2'd2
   } qbl_state_e;
endpackage

// File: rtl/qbl_addr_gen.sv
module qbl_addr_gen #(
   parameter int unsigned ADDR_W     = 64,
   parameter int unsigned SCALE_LOG2 = 3,
   parameter int unsigned ALIGN_LOG2 = 4,
   parameter int unsigned ID_W       = 5
) (
   input  logic [ADDR_W-1:0] base_val,
   input  logic [ADDR_W-1:0] index_val,
   input  logic              base_is_sp,
   input  logic [ID_W-1:0]   index_reg_id,
   output logic [ADDR_W-1:0] eff_addr,
   output logic              enc_bad,
   output logic              align_bad
);
   localparam logic [ID_W-1:0] RESERVED_ID = '1;

   initial begin
      if (ALIGN_LOG2 == 0 || ALIGN_LOG2 >= ADDR_W) $error("qbl_addr_gen: bad ALIGN_LOG2");
      if (SCALE_LOG2 >= ADDR_W) $error("qbl_addr_gen: bad SCALE_LOG2");
   end

   // Modulo 2^ADDR_W: the carry out of the adder is dropped.
   assign eff_addr  = base_val + (index_val << SCALE_LOG2);
   assign enc_bad   = (index_reg_id == RESERVED_ID);
   assign align_bad = base_is_sp && (base_val[ALIGN_LOG2-1:0] != '0);
endmodule

// File: rtl/qbl_fetch_seq.sv
module qbl_fetch_seq
   import qbl_pkg::*;
#(
   parameter int unsigned ADDR_W   = 64,
   parameter int unsigned ELEM_W   = 64,
   parameter int unsigned NUM_ELEM = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  logic [ADDR_W-1:0]          eff_addr,
   input  logic                       enc_bad,
   input  logic                       align_bad,
   input  logic [NUM_ELEM-1:0]        elem_act,
   output logic                       mem_req_valid,
   input  logic                       mem_req_ready,
   output logic [ADDR_W-1:0]          mem_req_addr,
   input  logic                       mem_rsp_valid,
   input  logic [ELEM_W-1:0]          mem_rsp_data,
   input  logic                       mem_rsp_err,
   output logic [ELEM_W*NUM_ELEM-1:0] quad_out,
   output logic                       done,
   output logic                       error
);
   localparam int unsigned QUAD_W      = ELEM_W * NUM_ELEM;
   localparam int unsigned EIDX_W      = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1;
   localparam int unsigned BYTE_STRIDE = ELEM_W / 8;

   qbl_state_e            state_q;
   logic [EIDX_W-1:0]     elem_q;
   logic [NUM_ELEM-1:0]   act_q;
   logic [ADDR_W-1:0]     addr_q;
   logic [QUAD_W-1:0]     work_q;
   logic [QUAD_W-1:0]     work_nxt;
   logic [QUAD_W-1:0]     res_q;
   logic                  done_q;
   logic                  err_q;
   logic [EIDX_W-1:0]     first_idx;
   logic [EIDX_W-1:0]     next_idx;
   logic                  next_found;

   // Lowest active element at start, and next active element above the current one.
   always_comb begin
      first_idx  = '0;
      next_idx   = '0;
      next_found = 1'b0;
      for (int e = NUM_ELEM - 1; e >= 0; e--) begin
         if (elem_act[e]) first_idx = EIDX_W'(e);
         if (act_q[e] && (e > int'(elem_q))) begin
            next_idx   = EIDX_W'(e);
            next_found = 1'b1;
         end
      end
   end

   always_comb begin
      work_nxt = work_q;
      work_nxt[int'(elem_q)*ELEM_W +: ELEM_W] = mem_rsp_data;
   end

   assign mem_req_valid = (state_q == QBL_REQ);
   assign mem_req_addr  = addr_q + (ADDR_W'(elem_q) * ADDR_W'(BYTE_STRIDE));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= QBL_IDLE;
         elem_q  <= '0;
         act_q   <= '0;
         addr_q  <= '0;
         work_q  <= '0;
         res_q   <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         unique case (state_q)
            QBL_IDLE: begin
               if (start) begin
                  act_q  <= elem_act;
                  addr_q <= eff_addr;
                  work_q <= '0;
                  elem_q <= first_idx;
                  if (enc_bad || align_bad) begin
                     done_q <= 1'b1;
                     err_q  <= 1'b1;
                  end else if (elem_act == '0) begin
                     done_q <= 1'b1;
                     res_q  <= '0;
                  end else begin
                     state_q <= QBL_REQ;
                  end
               end
            end
            QBL_REQ: begin
               if (mem_req_ready) state_q <= QBL_WAIT;
            end
            QBL_WAIT: begin
               if (mem_rsp_valid) begin
                  if (mem_rsp_err) begin
                     done_q  <= 1'b1;
                     err_q   <= 1'b1;
                     state_q <= QBL_IDLE;
                  end else if (next_found) begin
                     work_q  <= work_nxt;
                     elem_q  <= next_idx;
                     state_q <= QBL_REQ;
                  end else begin
                     work_q  <= work_nxt;
                     res_q   <= work_nxt;
                     done_q  <= 1'b1;
                     state_q <= QBL_IDLE;
                  end
               end
            end
            default: state_q <= QBL_IDLE;
         endcase
      end
   end

   assign quad_out = res_q;
   assign done     = done_q;
   assign error    = err_q;

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R8
   AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> done); // R9
   AST_UNDEF_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == QBL_IDLE) && start && enc_bad |=> done && error && !mem_req_valid); // R6
   AST_ALIGN_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == QBL_IDLE) && start && align_bad |=> done && error && !mem_req_valid); // R7
   AST_ONLY_ACTIVE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> act_q[elem_q]); // R3
   AST_RESULT_KEPT_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      done && error |-> $stable(quad_out)); // R10
endmodule

// File: rtl/qbl_tile.sv
module qbl_tile #(
   parameter int unsigned QUAD_W  = 128,
   parameter int unsigned VL_BITS = 512
) (
   input  logic [QUAD_W-1:0]  quad_in,
   output logic [VL_BITS-1:0] vec_out
);
   localparam int unsigned COPIES = VL_BITS / QUAD_W;

   for (genvar k = 0; k < COPIES; k++) begin : g_copy
      assign vec_out[k*QUAD_W +: QUAD_W] = quad_in;
   end
endmodule

// File: rtl/qbcast_load.sv
module qbcast_load
   import qbl_pkg::*;
#(
   parameter int unsigned VL_BITS = 512
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [63:0]           base_val,
   input  logic                  base_is_sp,
   input  logic [63:0]           index_val,
   input  logic [4:0]            index_reg_id,
   input  logic [15:0]           pred_slice,
   output logic                  mem_req_valid,
   input  logic                  mem_req_ready,
   output logic [63:0]           mem_req_addr,
   input  logic                  mem_rsp_valid,
   input  logic [63:0]           mem_rsp_data,
   input  logic                  mem_rsp_err,
   output logic [VL_BITS-1:0]    vec_out,
   output logic                  done,
   output logic                  error
);
   localparam int unsigned NUM_ELEM    = QBL_QUAD_W / QBL_ELEM_W;
   localparam int unsigned PRED_STRIDE = QBL_ELEM_W / 8;
   localparam int unsigned SCALE_LOG2  = $clog2(QBL_ELEM_W / 8);

   if ((VL_BITS % QBL_QUAD_W) != 0 || VL_BITS < QBL_VL_MIN || VL_BITS > QBL_VL_MAX) begin : g_bad_vl
      initial $error("qbcast_load: VL_BITS must be a multiple of 128 in [128,2048]");
   end

   logic [QBL_ADDR_W-1:0]         eff_addr;
   logic                          enc_bad;
   logic                          align_bad;
   logic [NUM_ELEM-1:0]           elem_act;
   logic [QBL_QUAD_W-1:0]         quad;

   // One enable bit per element, taken at the element's byte-lane position.
   for (genvar e = 0; e < NUM_ELEM; e++) begin : g_act
      assign elem_act[e] = pred_slice[e*PRED_STRIDE];
   end

   qbl_addr_gen #(
      .ADDR_W     (QBL_ADDR_W),
      .SCALE_LOG2 (SCALE_LOG2),
      .ALIGN_LOG2 (QBL_ALIGN_LOG2),
      .ID_W       (QBL_ID_W)
   ) u_addr (
      .base_val     (base_val),
      .index_val    (index_val),
      .base_is_sp   (base_is_sp),
      .index_reg_id (index_reg_id),
      .eff_addr     (eff_addr),
      .enc_bad      (enc_bad),
      .align_bad    (align_bad)
   );

   qbl_fetch_seq #(
      .ADDR_W   (QBL_ADDR_W),
      .ELEM_W   (QBL_ELEM_W),
      .NUM_ELEM (NUM_ELEM)
   ) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .start         (start),
      .eff_addr      (eff_addr),
      .enc_bad       (enc_bad),
      .align_bad     (align_bad),
      .elem_act      (elem_act),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_addr  (mem_req_addr),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data),
      .mem_rsp_err   (mem_rsp_err),
      .quad_out      (quad),
      .done          (done),
      .error         (error)
   );

   qbl_tile #(
      .QUAD_W  (QBL_QUAD_W),
      .VL_BITS (VL_BITS)
   ) u_tile (
      .quad_in (quad),
      .vec_out (vec_out)
   );

   AST_DONE_AFTER_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_req_valid); // R9
endmodule

// File: tb/qbcast_load_test.sv
`timescale 1ns/1ps
module qbcast_load_test;
   localparam int unsigned VL = 512;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [63:0]   base_val = '0;
   logic          base_is_sp = 1'b0;
   logic [63:0]   index_val = '0;
   logic [4:0]    index_reg_id = '0;
   logic [15:0]   pred_slice = '0;
   logic          mem_req_valid;
   logic          mem_req_ready;
   logic [63:0]   mem_req_addr;
   logic          mem_rsp_valid = 1'b0;
   logic [63:0]   mem_rsp_data = '0;
   logic          mem_rsp_err = 1'b0;
   logic [VL-1:0] vec_out;
   logic          done;
   logic          error;

   int            n_checks = 0;
   int            n_fails  = 0;
   int            stall_cfg = 0;
   logic          err_en_cfg = 1'b0;
   logic [63:0]   err_addr_cfg = '0;
   logic [VL-1:0] vec_model = '0;

   int            cyc = 0;
   int            start_cyc = 0;
   int            done_cyc = 0;
   int            last_rsp_cyc = 0;
   int            req_total = 0;
   int            overlap_cnt = 0;
   int            wait_cnt = 0;
   logic          outstanding = 1'b0;
   logic          rsp_pend = 1'b0;
   logic [63:0]   rsp_addr = '0;
   logic [63:0]   addr_log [16];

   always #4 clk = ~clk;

   qbcast_load #(.VL_BITS(VL)) uut (
      .clk (clk), .rst_n (rst_n), .start (start),
      .base_val (base_val), .base_is_sp (base_is_sp),
      .index_val (index_val), .index_reg_id (index_reg_id),
      .pred_slice (pred_slice),
      .mem_req_valid (mem_req_valid), .mem_req_ready (mem_req_ready),
      .mem_req_addr (mem_req_addr),
      .mem_rsp_valid (mem_rsp_valid), .mem_rsp_data (mem_rsp_data),
      .mem_rsp_err (mem_rsp_err),
      .vec_out (vec_out), .done (done), .error (error)
   );

   function automatic logic [63:0] mdata(input logic [63:0] a);
      return {a[31:0] ^ 32'h5A5A_0F0F, ~a[63:32]};
   endfunction

   function automatic logic [VL-1:0] tile(input logic [127:0] q);
      logic [VL-1:0] v;
      for (int k = 0; k < VL/128; k++) v[k*128 +: 128] = q;
      return v;
   endfunction

   assign mem_req_ready = (wait_cnt == 0);

   // Memory model and monitor
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (start) start_cyc <= cyc;
      if (done) done_cyc <= cyc;
      if (mem_req_valid && outstanding) overlap_cnt <= overlap_cnt + 1;
      if (!mem_req_valid || mem_req_ready) wait_cnt <= stall_cfg;
      else wait_cnt <= wait_cnt - 1;
      if (mem_rsp_valid) begin
         last_rsp_cyc <= cyc;
         outstanding  <= 1'b0;
      end
      if (mem_req_valid && mem_req_ready) begin
         addr_log[req_total % 16] <= mem_req_addr;
         req_total   <= req_total + 1;
         outstanding <= 1'b1;
         rsp_pend    <= 1'b1;
         rsp_addr    <= mem_req_addr;
      end else begin
         rsp_pend <= 1'b0;
      end
      mem_rsp_valid <= rsp_pend;
      mem_rsp_data  <= rsp_pend ? mdata(rsp_addr) : '0;
      mem_rsp_err   <= rsp_pend && err_en_cfg && (rsp_addr == err_addr_cfg);
   end

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [VL-1:0] act, input logic [VL-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic run_op(input string tag, input logic [63:0] b, input logic sp,
                         input logic [63:0] ix, input logic [4:0] id,
                         input logic [15:0] pr, input int stall,
                         input logic een, input logic [63:0] ea_err,
                         input bit busy_poke);
      logic [63:0]   ea;
      logic [63:0]   a;
      logic [63:0]   exp_addr [2];
      logic [127:0]  q;
      logic [VL-1:0] vec_seen;
      bit            rej;
      bit            merr;
      bit            exp_err;
      logic          err_seen;
      int            nreq;
      int            n0;
      int            w;
      ea   = b + (ix << 3);
      rej  = (id == 5'd31) || (sp && (b[3:0] != 4'h0));
      nreq = 0;
      merr = 0;
      q    = '0;
      if (!rej) begin
         for (int e = 0; e < 2; e++) begin
            if (!merr && pr[e*8]) begin
               a = ea + 64'(e * 8);
               exp_addr[nreq] = a;
               nreq++;
               if (een && a == ea_err) merr = 1;
               else q[e*64 +: 64] = mdata(a);
            end
         end
      end
      exp_err = rej || merr;
      if (!exp_err) vec_model = tile(q);

      @(negedge clk);
      stall_cfg = stall; err_en_cfg = een; err_addr_cfg = ea_err;
      base_val = b; base_is_sp = sp; index_val = ix; index_reg_id = id;
      pred_slice = pr; start = 1'b1;
      n0 = req_total;
      @(negedge clk);
      start = 1'b0;
      if (busy_poke) begin
         @(negedge clk);
         index_reg_id = 5'd31; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      w = 0;
      while (!done && w < 200) begin
         @(negedge clk);
         w++;
      end
      err_seen = error;
      vec_seen = vec_out;
      @(negedge clk);
      check(w < 200, tag, "done seen", VL'(w), VL'(0));
      check(err_seen == exp_err, tag, "error flag", VL'(err_seen), VL'(exp_err));
      check(vec_seen == vec_model, tag, "vec_out", vec_seen, vec_model);
      check(req_total - n0 == nreq, tag, "request count", VL'(req_total - n0), VL'(nreq));
      for (int k = 0; k < nreq; k++)
         check(addr_log[(n0 + k) % 16] == exp_addr[k], tag, "request address",
               VL'(addr_log[(n0 + k) % 16]), VL'(exp_addr[k]));
      if (nreq == 0)
         check(done_cyc == start_cyc + 1, tag, "done cycle after start",
               VL'(done_cyc - start_cyc), VL'(1));
      else
         check(done_cyc == last_rsp_cyc + 1, tag, "done cycle after response",
               VL'(done_cyc - last_rsp_cyc), VL'(1));
      check(!done && !error, tag, "done pulse width", VL'({done, error}), VL'(0));
   endtask

   task automatic t_reset();
      check(vec_out == '0, "R9", "reset vec_out", vec_out, '0);
      check(!done && !error, "R9", "reset done/error", VL'({done, error}), VL'(0));
      check(!mem_req_valid, "R8", "reset request", VL'(mem_req_valid), VL'(0));
   endtask

   // R1 R2 R5 R9: both elements active, plain base
   task automatic t_both();
      run_op("R2", 64'h0000_0000_0001_0000, 1'b0, 64'd5, 5'd3, 16'h0101, 0, 1'b0, '0, 0);
      check(vec_out[127:0] == vec_out[511:384], "R5", "tile copy", vec_out[511:384], vec_out[127:0]);
   endtask

   task automatic t_wrap();
      run_op("R1", 64'hFFFF_FFFF_FFFF_FFF0, 1'b0, 64'd4, 5'd0, 16'h0101, 0, 1'b0, '0, 0);
   endtask

   task automatic t_pred();
      run_op("R3", 64'h0000_0000_0000_4000, 1'b0, 64'd2, 5'd1, 16'h0001, 0, 1'b0, '0, 0);
      run_op("R3", 64'h0000_0000_0000_5000, 1'b0, 64'd7, 5'd1, 16'h0100, 0, 1'b0, '0, 0);
      run_op("R3", 64'h0000_0000_0000_6000, 1'b0, 64'd1, 5'd1, 16'hFEFE, 0, 1'b0, '0, 0);
   endtask

   task automatic t_ignored_bits();
      run_op("R4", 64'h0000_0000_0000_7008, 1'b0, 64'd3, 5'd2, 16'hFFFF, 0, 1'b0, '0, 0);
      run_op("R4", 64'h0000_0000_0000_7800, 1'b0, 64'd3, 5'd2, 16'h7E01, 0, 1'b0, '0, 0);
   endtask

   task automatic t_undef();
      run_op("R6", 64'h0000_0000_0000_8000, 1'b0, 64'd1, 5'd31, 16'h0101, 0, 1'b0, '0, 0);
   endtask

   task automatic t_align();
      run_op("R7", 64'h0000_0000_0000_9008, 1'b1, 64'd1, 5'd4, 16'h0101, 0, 1'b0, '0, 0);
      run_op("R7", 64'h0000_0000_0000_A000, 1'b1, 64'd1, 5'd4, 16'h0101, 0, 1'b0, '0, 0);
      run_op("R7", 64'h0000_0000_0000_B003, 1'b0, 64'd1, 5'd4, 16'h0101, 0, 1'b0, '0, 0);
   endtask

   task automatic t_stall();
      run_op("R8", 64'h0000_0000_0000_C000, 1'b0, 64'd9, 5'd6, 16'h0101, 3, 1'b0, '0, 0);
      check(overlap_cnt == 0, "R8", "request while response pending", VL'(overlap_cnt), VL'(0));
   endtask

   task automatic t_mem_err();
      run_op("R10", 64'h0000_0000_0000_D000, 1'b0, 64'd0, 5'd6, 16'h0101, 0, 1'b1,
             64'h0000_0000_0000_D000, 0);
      run_op("R10", 64'h0000_0000_0000_E000, 1'b0, 64'd0, 5'd6, 16'h0101, 1, 1'b1,
             64'h0000_0000_0000_E008, 0);
   endtask

   task automatic t_busy();
      run_op("R11", 64'h0000_0000_0000_F000, 1'b0, 64'd2, 5'd7, 16'h0101, 4, 1'b0, '0, 1);
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_both();
      t_wrap();
      t_pred();
      t_ignored_bits();
      t_undef();
      t_align();
      t_stall();
      t_mem_err();
      t_busy();
      repeat (3) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end
endmodule